// File: doc/BRIEF.md
# Nine-Level Cascaded H-Bridge Switching-State Sequencer

This block drives the gates of a three-phase inverter whose phases are each built from two H-bridge cells in series. One cell sits on a DC source of one unit (E) and the other on three units (3E), so each phase reaches nine levels, from -4E to +4E. For each PWM period an upstream modulator supplies the three nearest space vectors, already ordered small, medium, large, as signed per-phase level targets, together with one dwell count per vector. A one-cycle period strobe starts the period.

The block splits each phase level into signed states for the two cells. It picks a zero state for a cell by alternating between the two legal switch pairs. It then plays the vectors as a mirrored pattern: small, medium, large in the first half, and large, medium, small in the second half. Each dwell is halved between the two halves, and the odd cycle goes to the first half. All gate outputs are registered and change only where one segment ends and the next begins. When the three vectors are mutually adjacent, no phase ever steps by more than one level.

Top module: `chb9_state_seq`

## Requirements
- R1: While `rst` is high, and afterwards until the first accepted `period_start`, every gate output is low.
- R2: Each cell drives four gates ordered {s4,s3,s2,s1}. State +1 gives 0011, state -1 gives 1100, and state 0 gives 0101 (top pair) or 1010 (bottom pair). Phase p, cell c (0 = E cell, 1 = 3E cell) occupies `gate[(p*2+c)*4 +: 4]`.
- R3: A phase level L becomes a 3E-cell state of sign(L) when |L| >= 2, and 0 otherwise. The E cell takes L minus three times the 3E-cell state.
- R4: Vector v, phase p is a 4-bit two's-complement field at `vec_lvl[(v*NPH+p)*4 +: 4]`, with v = 0, 1, 2 for small, medium and large. A value above +4 is treated as +4, and one below -4 as -4.
- R5: When a cell enters state 0 from a nonzero state, or from the all-off reset state, it uses the pair it did not use last time. The first zero after reset uses the top pair. A cell that stays at 0 keeps its pair.
- R6: Within a period the segments run in the order v0, v1, v2, v2, v1, v0.
- R7: With dwell d for vector v (`dwell[v*DW +: DW]`), its first-half segment lasts ceil(d/2) cycles and its second-half segment lasts floor(d/2) cycles. Segments of length zero are skipped.
- R8: When `period_start` is high at a clock edge, the first non-empty segment's state appears at the outputs after that same edge. Each later segment appears exactly when the previous one's cycles run out.
- R9: After the last segment, the outputs hold their state until the next `period_start`. A period whose dwells are all zero leaves the outputs unchanged.
- R10: A `period_start` that arrives mid-period abandons the running period and begins the new one at once.
- R11: When the three vectors of a period differ pairwise by at most one level in every phase, each phase moves by at most one level at every change inside the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | One-cycle strobe that latches the vectors and dwells and starts a period |
| vec_lvl | input | 3*NPH*4 | Signed level targets of the three vectors, per phase |
| dwell | input | 3*DW | Dwell count of each vector for the whole period, in cycles |
| gate | output | NPH*8 | Registered gate drives, four per cell, two cells per phase |

## Verification
The bench builds the block with NPH = 3 and DW = 5. A dwell width of five bits makes the largest count (31) cheap to reach, along with counts of zero and one, where a half-segment vanishes, and odd counts, where the extra cycle must land in the first half. Three phases are enough to drive every cell through positive, negative and saturated levels and through repeated zero entries, so the pair alternation is exercised. A restart in the middle of a period and an all-zero period are also covered.

// File: rtl/chb9_pkg.sv
`timescale 1ns/1ps
package chb9_pkg;
  localparam int LVL_W = 4;
  localparam int NVEC  = 3;
  localparam int NSEG  = 2 * NVEC;

  typedef logic signed [LVL_W-1:0] lvl_t;
  typedef logic signed [1:0]       cell_t;

  localparam logic [3:0] G_POS  = 4'b0011;
  localparam logic [3:0] G_NEG  = 4'b1100;
  localparam logic [3:0] G_ZTOP = 4'b0101;
  localparam logic [3:0] G_ZBOT = 4'b1010;

  localparam lvl_t LVL_MAX = 4'sd4;
  localparam lvl_t LVL_MIN = -4'sd4;

  function automatic lvl_t sat_lvl(lvl_t x);
    if (x > LVL_MAX) return LVL_MAX;
    if (x < LVL_MIN) return LVL_MIN;
    return x;
  endfunction

  // state of the 3E cell for a phase level
  function automatic cell_t coarse_of(lvl_t x);
    if (x >= 4'sd2)  return 2'sd1;
    if (x <= -4'sd2) return cell_t'(-1);
    return 2'sd0;
  endfunction

  // remainder carried by the E cell
  function automatic cell_t fine_of(lvl_t x, cell_t c);
    lvl_t r;
    r = x - (lvl_t'(c) * 4'sd3);
    return cell_t'(r);
  endfunction
endpackage

// File: rtl/chb9_cell_drv.sv
`timescale 1ns/1ps
module chb9_cell_drv
  import chb9_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  cell_t      st,
  output logic [3:0] gate
);
  logic  on_q;
  cell_t cur_q;
  logic  zl_q;   // last zero pair used: 0 top, 1 bottom

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      cur_q <= '0;
      zl_q  <= 1'b1;
      gate  <= '0;
    end else if (load) begin
      on_q  <= 1'b1;
      cur_q <= st;
      if (st == 2'sd0) begin
        if (!on_q || cur_q != 2'sd0) begin
          gate <= zl_q ? G_ZTOP : G_ZBOT;
          zl_q <= ~zl_q;
        end
      end else if (st[1]) begin
        gate <= G_NEG;
      end else begin
        gate <= G_POS;
      end
    end
  end

  AST_GATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (gate == 4'b0000 || gate == G_POS || gate == G_NEG ||
     gate == G_ZTOP || gate == G_ZBOT)); // R2

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(gate)); // R8
endmodule

// File: rtl/chb9_seg_ctrl.sv
`timescale 1ns/1ps
module chb9_seg_ctrl
  import chb9_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NVEC*DW-1:0] dwell,
  output logic              apply,
  output logic [1:0]        vsel
);
  localparam logic [2:0] SEG_IDLE = 3'(NSEG);

  logic [DW-1:0] fh_new [NVEC];
  logic [DW-1:0] sh_new [NVEC];
  logic [DW-1:0] fh_q   [NVEC];
  logic [DW-1:0] sh_q   [NVEC];
  logic [DW-1:0] len_new [8];
  logic [DW-1:0] len_q   [8];
  logic [2:0]    seg_q, nxt_start, nxt_adv;
  logic [DW-1:0] cnt_q;
  logic          adv;

  for (genvar v = 0; v < NVEC; v++) begin : g_half
    logic [DW:0] d_ext;
    assign d_ext     = {1'b0, dwell[v*DW +: DW]};
    assign fh_new[v] = DW'((d_ext + (DW+1)'(1)) >> 1);
    assign sh_new[v] = dwell[v*DW +: DW] >> 1;
  end

  always_comb begin
    for (int s = 0; s < 8; s++) begin
      len_new[s] = '0;
      len_q[s]   = '0;
    end
    for (int v = 0; v < NVEC; v++) begin
      len_new[v]        = fh_new[v];
      len_new[NSEG-1-v] = sh_new[v];
      len_q[v]          = fh_q[v];
      len_q[NSEG-1-v]   = sh_q[v];
    end
  end

  always_comb begin
    nxt_start = SEG_IDLE;
    nxt_adv   = SEG_IDLE;
    for (int s = NSEG-1; s >= 0; s--) begin
      if (len_new[s] != '0) nxt_start = 3'(s);
      if ((3'(s) > seg_q) && (len_q[s] != '0)) nxt_adv = 3'(s);
    end
  end

  function automatic logic [1:0] seg_vec(logic [2:0] s);
    return (s < 3'(NVEC)) ? s[1:0] : 2'(3'(NSEG-1) - s);
  endfunction

  assign adv   = (seg_q != SEG_IDLE) && (cnt_q == '0);
  assign apply = start ? (nxt_start != SEG_IDLE) : (adv && (nxt_adv != SEG_IDLE));
  assign vsel  = seg_vec(start ? nxt_start : nxt_adv);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= SEG_IDLE;
      cnt_q <= '0;
      for (int v = 0; v < NVEC; v++) begin
        fh_q[v] <= '0;
        sh_q[v] <= '0;
      end
    end else if (start) begin
      for (int v = 0; v < NVEC; v++) begin
        fh_q[v] <= fh_new[v];
        sh_q[v] <= sh_new[v];
      end
      seg_q <= nxt_start;
      cnt_q <= (nxt_start != SEG_IDLE) ? len_new[nxt_start] - DW'(1) : '0;
    end else if (seg_q != SEG_IDLE) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - DW'(1);
      end else begin
        seg_q <= nxt_adv;
        cnt_q <= (nxt_adv != SEG_IDLE) ? len_q[nxt_adv] - DW'(1) : '0;
      end
    end
  end

  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (rst)
    seg_q <= SEG_IDLE); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (seg_q != SEG_IDLE) |-> (cnt_q < len_q[seg_q])); // R7
endmodule

// File: rtl/chb9_state_seq.sv
`timescale 1ns/1ps
module chb9_state_seq
  import chb9_pkg::*;
#(
  parameter int NPH = 3,
  parameter int DW  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        period_start,
  input  logic [NVEC*NPH*LVL_W-1:0]   vec_lvl,
  input  logic [NVEC*DW-1:0]          dwell,
  output logic [NPH*8-1:0]            gate
);
  logic       apply;
  logic [1:0] vsel;
  lvl_t       lvl_q [NVEC][NPH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < NVEC; v++)
        for (int p = 0; p < NPH; p++)
          lvl_q[v][p] <= '0;
    end else if (period_start) begin
      for (int v = 0; v < NVEC; v++)
        for (int p = 0; p < NPH; p++)
          lvl_q[v][p] <= sat_lvl(lvl_t'(vec_lvl[(v*NPH+p)*LVL_W +: LVL_W]));
    end
  end

  chb9_seg_ctrl #(.DW(DW)) seg_i (
    .clk   (clk),
    .rst   (rst),
    .start (period_start),
    .dwell (dwell),
    .apply (apply),
    .vsel  (vsel)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    lvl_t  src;
    cell_t st_big, st_small;
    lvl_t  app_lvl;
    logic  app_ok;
    logic signed [LVL_W:0] step;

    always_comb begin
      src = '0;
      for (int v = 0; v < NVEC; v++) begin
        if (vsel == 2'(v))
          src = period_start ? sat_lvl(lvl_t'(vec_lvl[(v*NPH+p)*LVL_W +: LVL_W]))
                             : lvl_q[v][p];
      end
    end

    assign st_big   = coarse_of(src);
    assign st_small = fine_of(src, st_big);

    chb9_cell_drv cell_e_i (
      .clk  (clk),
      .rst  (rst),
      .load (apply),
      .st   (st_small),
      .gate (gate[(p*2+0)*4 +: 4])
    );

    chb9_cell_drv cell_3e_i (
      .clk  (clk),
      .rst  (rst),
      .load (apply),
      .st   (st_big),
      .gate (gate[(p*2+1)*4 +: 4])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        app_lvl <= '0;
        app_ok  <= 1'b0;
      end else if (apply) begin
        app_lvl <= src;
        app_ok  <= 1'b1;
      end
    end

    assign step = (LVL_W+1)'(src) - (LVL_W+1)'(app_lvl);

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
      (apply && !period_start && app_ok) |-> (step <= 5'sd1 && step >= -5'sd1)); // R11
  end
endmodule

// File: tb/chb9_state_seq_tb_top.sv
`timescale 1ns/1ps
module chb9_state_seq_tb_top;
  import chb9_pkg::*;
  localparam int NPH = 3;
  localparam int DW  = 5;
  localparam int GW  = NPH * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic period_start = 1'b0;
  logic [NVEC*NPH*LVL_W-1:0] vec_lvl = '0;
  logic [NVEC*DW-1:0]        dwell   = '0;
  logic [GW-1:0]             gate;

  always #2.5 clk = ~clk;

  chb9_state_seq #(.NPH(NPH), .DW(DW)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .period_start (period_start),
    .vec_lvl      (vec_lvl),
    .dwell        (dwell),
    .gate         (gate)
  );

  int bv [3][3];
  int bd [3];
  int mvec [3][3];
  int q [$];
  bit mon [6];
  int mcur [6];
  bit mzl [6];
  logic [GW-1:0] exp_g;
  string cur_req = "R1";
  int n_cmp = 0;
  int n_bad = 0;
  int prev_lvl [3];
  bit prev_ok = 0;

  function automatic int satb(int x);
    return (x > 4) ? 4 : ((x < -4) ? -4 : x);
  endfunction

  function automatic int cell_val(logic [3:0] g);
    if (g == 4'b0011) return 1;
    if (g == 4'b1100) return -1;
    return 0;
  endfunction

  task automatic cell_upd(int k, int s);
    if (s == 0) begin
      if (!mon[k] || mcur[k] != 0) begin
        exp_g[k*4 +: 4] = mzl[k] ? 4'b0101 : 4'b1010;
        mzl[k] = !mzl[k];
      end
    end else begin
      exp_g[k*4 +: 4] = (s > 0) ? 4'b0011 : 4'b1100;
    end
    mcur[k] = s;
    mon[k]  = 1'b1;
  endtask

  task automatic m_apply(int vi);
    for (int p = 0; p < NPH; p++) begin
      int l, b;
      l = mvec[vi][p];
      b = (l >= 2) ? 1 : ((l <= -2) ? -1 : 0);
      cell_upd(p*2, l - 3*b);
      cell_upd(p*2+1, b);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      q.delete();
      for (int k = 0; k < 6; k++) begin
        mon[k] = 0; mcur[k] = 0; mzl[k] = 1;
      end
      exp_g = '0;
    end else if (period_start) begin
      for (int v = 0; v < 3; v++)
        for (int p = 0; p < NPH; p++)
          mvec[v][p] = satb(bv[v][p]);
      q.delete();
      for (int s = 0; s < 6; s++) begin
        int vi, len;
        vi  = (s < 3) ? s : 5 - s;
        len = (s < 3) ? (bd[vi] + 1) / 2 : bd[vi] / 2;
        for (int n = 0; n < len; n++) q.push_back(vi);
      end
      if (q.size() > 0) m_apply(q.pop_front());
    end else if (q.size() > 0) begin
      m_apply(q.pop_front());
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (gate !== exp_g) begin
      n_bad++;
      $display("FAIL %s: gate=%h expected=%h at %0t", cur_req, gate, exp_g, $time);
    end
    // R11: one-level steps inside a period, seen from decoded gates
    if (!rst && prev_ok && !period_start) begin
      for (int p = 0; p < NPH; p++) begin
        int lv, df;
        lv = cell_val(gate[(p*2)*4 +: 4]) + 3 * cell_val(gate[(p*2+1)*4 +: 4]);
        df = lv - prev_lvl[p];
        n_cmp++;
        if (df > 1 || df < -1) begin
          n_bad++;
          $display("FAIL R11: phase %0d step=%0d expected |step|<=1", p, df);
        end
      end
    end
    for (int p = 0; p < NPH; p++)
      prev_lvl[p] = cell_val(gate[(p*2)*4 +: 4]) + 3 * cell_val(gate[(p*2+1)*4 +: 4]);
    prev_ok = !rst && (gate != '0);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    compare();
  endtask

  task automatic setv(int v, int a, int b, int c);
    bv[v][0] = a; bv[v][1] = b; bv[v][2] = c;
  endtask

  task automatic launch();
    for (int v = 0; v < 3; v++) begin
      for (int p = 0; p < NPH; p++)
        vec_lvl[(v*NPH+p)*4 +: 4] = 4'(bv[v][p]);
      dwell[v*DW +: DW] = DW'(bd[v]);
    end
    period_start = 1'b1;
    tick();
    period_start = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state and idle before first strobe
    cur_req = "R1";
    repeat (3) tick();
    rst = 1'b0;
    repeat (4) tick();

    // R6 R8 R2 R3 R5: mirrored order, odd dwell split
    cur_req = "R6";
    setv(0, 1, 0, -1); setv(1, 2, 0, -1); setv(2, 2, 1, -1);
    bd = '{5, 4, 3};
    launch();
    repeat (11) tick();
    // R9: hold after the sequence
    cur_req = "R9";
    repeat (4) tick();

    // R3: negative and top levels
    cur_req = "R3";
    setv(0, -3, 4, 0); setv(1, -4, 4, 0); setv(2, -4, 3, 1);
    bd = '{2, 7, 1};
    launch();
    repeat (12) tick();

    // R7: zero-length segments skipped, dwell of one
    cur_req = "R7";
    setv(0, 0, -1, 1); setv(1, 1, -1, 1); setv(2, 1, -2, 1);
    bd = '{0, 1, 6};
    launch();
    repeat (9) tick();

    // R7: largest dwell counts
    setv(0, 2, 3, -2); setv(1, 3, 3, -2); setv(2, 3, 4, -2);
    bd = '{31, 31, 1};
    launch();
    repeat (66) tick();

    // R9: all-zero period leaves outputs unchanged
    cur_req = "R9";
    bd = '{0, 0, 0};
    setv(0, -4, -4, -4); setv(1, -4, -4, -4); setv(2, -4, -4, -4);
    launch();
    repeat (5) tick();

    // R10: restart mid-period
    cur_req = "R10";
    setv(0, 0, 1, 2); setv(1, 1, 1, 2); setv(2, 1, 2, 2);
    bd = '{10, 10, 10};
    launch();
    repeat (6) tick();
    setv(0, -1, 0, 0); setv(1, -1, 1, 0); setv(2, -2, 1, 0);
    bd = '{3, 3, 3};
    launch();
    repeat (12) tick();

    // R4: saturation of out-of-range levels
    cur_req = "R4";
    setv(0, 7, -8, 0); setv(1, 5, -5, 1); setv(2, 4, -4, 1);
    bd = '{3, 2, 2};
    launch();
    repeat (10) tick();

    // R5: repeated zero entries alternate pairs
    cur_req = "R5";
    setv(0, 0, 0, 0); setv(1, 1, 0, 0); setv(2, 1, 1, 0);
    bd = '{2, 2, 2};
    for (int r = 0; r < 3; r++) begin
      launch();
      repeat (7) tick();
    end

    // R2: encoding checked on every compare; final settle
    cur_req = "R2";
    repeat (3) tick();

    summary();
    $finish;
  end
endmodule